// File: doc/BRIEF.md
# Programmable Expansion Bus Cycle Controller

This block turns single read and write requests from a synchronous internal port into cycles on an 8-bit asynchronous slave bus with up to eight byte-wide peripherals, each on its own active-low select line. The request carries a device number, a 16-bit address, a write flag and write data. The low address byte drives dedicated pins for the whole cycle. The high byte is put on the shared data bus for one cycle, with a latch-enable pulse so that an external latch can capture it.

Four timing fields, each 4 bits wide, shape every cycle. All of them count the bus clock, and a value of n gives n+1 cycles, so no phase is ever empty. Setup is the select-to-strobe time. Pulse is the strobe width. Hold is the time the select stays low after the strobe. Recovery is the minimum gap from the end of one strobe to the start of the next. A ready input from the peripheral stretches the strobe. Read data is captured on the clock edge that ends the strobe and is returned with a one-cycle done pulse. The timing fields are loaded only while the controller is idle.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: In reset and after it, every select is high, both strobes are high, the latch enable is low, the data bus is not driven, `rsp_done` is low and `req_ready` is high. All four timing fields reset to 15.
- R2: The cycle after a request is accepted, `bus_latch_en` is high for exactly one cycle. In that cycle `bus_data_oe` is 1, `bus_data_out` carries address bits 15:8 and all selects are high. `bus_addr_lo` shows address bits 7:0 for every cycle in which a select is low.
- R3: From the start of setup to the end of hold, exactly one select is low: `bus_cs_n[k]`, where k is `req_dev`. Any strobe is seen only while a select is low.
- R4: The select is low for setup+1 cycles before the strobe starts, unless recovery (R8) delays the strobe.
- R5: A write uses `bus_wr_n` and a read uses `bus_rd_n`. The two are never low together. With ready high, the strobe lasts pulse+1 cycles.
- R6: The strobe ends only on an edge at which `bus_rdy` is 1. If ready is low for the first W strobe cycles, the strobe lasts max(pulse, W)+1 cycles.
- R7: The select stays low for hold+1 cycles after the strobe rises.
- R8: Between the rise of one strobe and the fall of the next there are at least recovery+1 strobe-free cycles. The recovery value used is the one in force when the earlier strobe ended. Setup is stretched to the earliest cycle that meets both R4 and R8.
- R9: During a write, `bus_data_oe` is 1 and `bus_data_out` equals the write data in every cycle in which the select is low. During a read, `bus_data_oe` is 0 in those cycles.
- R10: `rsp_done` is a one-cycle pulse in the first cycle after hold ends. For a read, `rsp_rdata` then holds the `bus_data_in` value sampled on the edge that ended the strobe.
- R11: `req_ready` is 1 only while the controller is idle. A request is accepted on an edge where `req_valid` and `req_ready` are both 1, and each accepted request produces exactly one bus cycle.
- R12: `cfg_we` loads the four timing fields only while the controller is idle. A write made during a cycle has no effect on any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the timing fields (taken only when idle) |
| cfg_setup | input | 4 | Select-to-strobe cycles minus one |
| cfg_pulse | input | 4 | Strobe width cycles minus one |
| cfg_hold | input | 4 | Select hold cycles minus one |
| cfg_recov | input | 4 | Minimum strobe gap cycles minus one |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_dev | input | 3 | Target peripheral number |
| req_addr | input | 16 | Byte address within the peripheral |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done |
| bus_addr_lo | output | 8 | Directly driven low address |
| bus_latch_en | output | 1 | Enable for the external high-address latch |
| bus_cs_n | output | 8 | Active-low peripheral selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_data_out | output | 8 | Data bus output value |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_data_in | input | 8 | Data bus input value |
| bus_rdy | input | 1 | Peripheral ready; high when undriven |

## Verification
The latch pulse is due one cycle after the accepting edge, and the select one cycle after that. The strobe is due after setup+1 select cycles or after recovery+1 strobe-free cycles, whichever comes later. The strobe lasts max(pulse, ready-wait)+1 cycles, and `rsp_done` with the read data comes in the first cycle after hold+1 hold cycles. The bench samples every output on the falling clock edge and counts the select, strobe and hold cycles of each bus cycle. It compares those counts with the queued item's expected values, and for the strobe start it checks the earliest legal cycle rather than a fixed offset. The peripheral model returns a different data byte in each strobe cycle, so a capture one edge early or late gives a wrong value.

// File: rtl/xbc_pkg.sv
`timescale 1ns/1ps
package xbc_pkg;
  localparam int XBC_TW = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } xbc_state_e;

  typedef struct packed {
    logic [XBC_TW-1:0] setup;
    logic [XBC_TW-1:0] pulse;
    logic [XBC_TW-1:0] hold;
    logic [XBC_TW-1:0] recov;
  } xbc_timing_t;
endpackage

// File: rtl/xbc_timing_regs.sv
`timescale 1ns/1ps
module xbc_timing_regs
  import xbc_pkg::*;
#(
  parameter logic [XBC_TW-1:0] RST_VAL = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idle,
  input  logic        wr_en,
  input  xbc_timing_t wr_val,
  output xbc_timing_t tim
);
  xbc_timing_t tim_q, tim_d;
  logic        load;

  // writes accepted only between cycles
  assign load = wr_en & idle;

  always_comb begin
    tim_d = tim_q;
    if (load) tim_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tim_q <= '{setup: RST_VAL, pulse: RST_VAL, hold: RST_VAL, recov: RST_VAL};
    else        tim_q <= tim_d;
  end

  assign tim = tim_q;
endmodule

// File: rtl/xbc_recovery.sv
`timescale 1ns/1ps
module xbc_recovery
  import xbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_on,
  input  logic              strobe_end,
  input  logic [XBC_TW-1:0] recov,
  output logic              rec_ok
);
  logic [XBC_TW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (strobe_end)                       left_d = recov;
    else if (!strobe_on && left_q != '0)  left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign rec_ok = (left_q == '0);
endmodule

// File: rtl/xbc_cs_decode.sv
`timescale 1ns/1ps
module xbc_cs_decode #(
  parameter int DEV_N = 8,
  localparam int DEV_W = $clog2(DEV_N)
) (
  input  logic             active,
  input  logic [DEV_W-1:0] dev,
  output logic [DEV_N-1:0] cs_n
);
  for (genvar i = 0; i < DEV_N; i++) begin : g_sel
    assign cs_n[i] = ~(active && (dev == DEV_W'(i)));
  end
endmodule

// File: rtl/xbc_sequencer.sv
`timescale 1ns/1ps
module xbc_sequencer
  import xbc_pkg::*;
#(
  parameter int DEV_W  = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  xbc_timing_t       tim,
  input  logic              rec_ok,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_din,
  output xbc_state_e        st,
  output logic              strobe_end,
  output logic [DEV_W-1:0]  dev_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);
  xbc_state_e        st_q, st_d;
  logic [XBC_TW-1:0] cnt_q, cnt_d;
  logic              done_d;
  logic              take;
  logic              cap_rd;

  assign take   = req_valid && (st_q == ST_IDLE);
  assign cap_rd = strobe_end && !wr_q;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    done_d     = 1'b0;
    strobe_end = 1'b0;
    case (st_q)
      ST_IDLE:   if (req_valid) st_d = ST_ADDR;
      ST_ADDR: begin
        st_d  = ST_SETUP;
        cnt_d = tim.setup;
      end
      ST_SETUP: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (rec_ok) begin
          st_d  = ST_STROBE;
          cnt_d = tim.pulse;
        end
      end
      ST_STROBE: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (bus_rdy) begin
          st_d       = ST_HOLD;
          cnt_d      = tim.hold;
          strobe_end = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // request capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q   <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (take) begin
      dev_q   <= req_dev;
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  // read data taken on the edge that ends the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= bus_din;
  end

  assign st = st_q;
endmodule

// File: rtl/xbus_cycle_ctrl.sv
`timescale 1ns/1ps
module xbus_cycle_ctrl
  import xbc_pkg::*;
#(
  parameter int DEV_N  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LO_W   = 8,
  localparam int DEV_W = $clog2(DEV_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [XBC_TW-1:0] cfg_setup,
  input  logic [XBC_TW-1:0] cfg_pulse,
  input  logic [XBC_TW-1:0] cfg_hold,
  input  logic [XBC_TW-1:0] cfg_recov,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [LO_W-1:0]   bus_addr_lo,
  output logic              bus_latch_en,
  output logic [DEV_N-1:0]  bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_data_in,
  input  logic              bus_rdy
);
  logic [1:0]        rst_sync;
  logic              core_rst_n;
  xbc_state_e        st;
  xbc_timing_t       tim_cur;
  xbc_timing_t       tim_wr;
  logic              strobe_end, rec_ok, idle, sel_on, strobe_on, addr_ph;
  logic [DEV_W-1:0]  dev_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  assign tim_wr = '{setup: cfg_setup, pulse: cfg_pulse, hold: cfg_hold, recov: cfg_recov};

  assign idle      = (st == ST_IDLE);
  assign addr_ph   = (st == ST_ADDR);
  assign strobe_on = (st == ST_STROBE);
  assign sel_on    = (st == ST_SETUP) || strobe_on || (st == ST_HOLD);

  xbc_timing_regs i_timing (
    .clk(clk), .rst_n(core_rst_n), .idle(idle), .wr_en(cfg_we),
    .wr_val(tim_wr), .tim(tim_cur)
  );

  xbc_recovery i_recov (
    .clk(clk), .rst_n(core_rst_n), .strobe_on(strobe_on),
    .strobe_end(strobe_end), .recov(tim_cur.recov), .rec_ok(rec_ok)
  );

  xbc_sequencer #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk(clk), .rst_n(core_rst_n), .req_valid(req_valid), .req_dev(req_dev),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .tim(tim_cur), .rec_ok(rec_ok), .bus_rdy(bus_rdy), .bus_din(bus_data_in),
    .st(st), .strobe_end(strobe_end), .dev_q(dev_q), .addr_q(addr_q),
    .wr_q(wr_q), .wdata_q(wdata_q), .rdata_q(rsp_rdata), .done_q(rsp_done)
  );

  xbc_cs_decode #(.DEV_N(DEV_N)) i_dec (
    .active(sel_on), .dev(dev_q), .cs_n(bus_cs_n)
  );

  assign req_ready    = idle;
  assign bus_latch_en = addr_ph;
  assign bus_rd_n     = ~(strobe_on && !wr_q);
  assign bus_wr_n     = ~(strobe_on && wr_q);
  assign bus_addr_lo  = addr_q[LO_W-1:0];
  assign bus_data_oe  = addr_ph || (sel_on && wr_q);
  assign bus_data_out = addr_ph ? DATA_W'(addr_q[ADDR_W-1:LO_W]) : wdata_q;
endmodule

// File: rtl/xbc_checker.sv
`timescale 1ns/1ps
module xbc_checker
  import xbc_pkg::*;
#(
  parameter int DEV_N = 8,
  parameter int LO_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DEV_N-1:0]  cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              latch_en,
  input logic              data_oe,
  input logic [LO_W-1:0]   addr_lo,
  input logic              rdy,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [XBC_TW-1:0] recov
);
  logic              stb, stb_q, have_prev;
  logic [5:0]        gap;
  logic [XBC_TW-1:0] cap_recov;

  assign stb = !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q     <= 1'b0;
      gap       <= '0;
      have_prev <= 1'b0;
      cap_recov <= '0;
    end else begin
      stb_q <= stb;
      if (stb)               gap <= '0;
      else if (gap != 6'h3F) gap <= gap + 1'b1;
      if (!stb && stb_q) begin
        have_prev <= 1'b1;
        cap_recov <= recov;
      end
    end
  end

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  p_cs_onehot_r3:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  p_strobe_cs_r3:   assert property (@(posedge clk) disable iff (!rst_n) stb |-> !(&cs_n));
  p_latch_bus_r2:   assert property (@(posedge clk) disable iff (!rst_n)
                      latch_en |-> (&cs_n && data_oe && rd_n && wr_n));
  p_latch_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) latch_en |=> !latch_en);
  p_addr_hold_r2:   assert property (@(posedge clk) disable iff (!rst_n)
                      !(&cs_n) |=> (&cs_n || $stable(addr_lo)));
  p_read_float_r9:  assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !data_oe);
  p_rdy_rd_r6:      assert property (@(posedge clk) disable iff (!rst_n) (!rd_n && !rdy) |=> !rd_n);
  p_rdy_wr_r6:      assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && !rdy) |=> !wr_n);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done);
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
                      req_ready |-> (&cs_n && !latch_en && rd_n && wr_n));
  p_recov_gap_r8:   assert property (@(posedge clk) disable iff (!rst_n)
                      (stb && !stb_q && have_prev) |-> (gap >= 6'(cap_recov) + 6'd1));
endmodule

bind xbus_cycle_ctrl xbc_checker #(.DEV_N(DEV_N), .LO_W(LO_W)) i_xbc_checker (
  .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
  .latch_en(bus_latch_en), .data_oe(bus_data_oe), .addr_lo(bus_addr_lo),
  .rdy(bus_rdy), .req_ready(req_ready), .rsp_done(rsp_done), .recov(tim_cur.recov)
);

// File: tb/test_xbus_cycle_ctrl.sv
`timescale 1ns/1ps
module test_xbus_cycle_ctrl;
  localparam real CLK_PERIOD = 30.0;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0, cfg_recov = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_dev = '0;
  logic [15:0] req_addr = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_done;
  logic [7:0] rsp_rdata;
  logic [7:0] bus_addr_lo;
  logic       bus_latch_en;
  logic [7:0] bus_cs_n;
  logic       bus_rd_n, bus_wr_n;
  logic [7:0] bus_data_out;
  logic       bus_data_oe;
  logic [7:0] bus_data_in = 8'hEE;
  logic       bus_rdy = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_cycle_ctrl i_xbus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_setup(cfg_setup),
    .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold), .cfg_recov(cfg_recov),
    .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr_lo(bus_addr_lo),
    .bus_latch_en(bus_latch_en), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_data_in(bus_data_in), .bus_rdy(bus_rdy)
  );

  typedef struct {
    logic [2:0]  dev;
    logic [15:0] addr;
    logic        wr;
    logic [7:0]  wdata;
    logic [7:0]  rbase;
    int          wt, setup, pulse, hold, recov;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  int m_setup = 15, m_pulse = 15, m_hold = 15, m_recov = 15;  // R1 reset values

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // peripheral model and scoreboard monitor, all on the falling edge
  int  sidx = 0, cyc = 0;
  bit  in_cyc = 0, have_prev = 0;
  int  pre, slen, hlen, gap = 0, prev_recov = 0;
  bit  bad_cs, bad_a, bad_d, bad_k;

  always @(negedge clk) begin
    bit stb, cs_act, ok_s, ok_r, tight;
    int exp_s;
    item_t it;
    cyc++;
    if (cyc > WATCHDOG) begin
      check(0, "watchdog", cyc, WATCHDOG);
      finish_run();
    end
    if (rst_n) begin
      stb = !bus_rd_n || !bus_wr_n;
      if (stb && q.size() > 0) begin
        bus_rdy     = (sidx >= q[0].wt);
        bus_data_in = q[0].rbase + 8'(sidx);
        sidx++;
      end else begin
        sidx = 0;
        bus_rdy = 1'b1;
        bus_data_in = 8'hEE;
      end
      if (bus_latch_en && q.size() > 0)  // R2 high address on the data bus
        check(bus_data_oe && bus_data_out == q[0].addr[15:8] && (&bus_cs_n),
              "R2 latch phase", bus_data_out, q[0].addr[15:8]);
      cs_act = (bus_cs_n != 8'hFF);
      if (cs_act && q.size() > 0) begin
        if (!in_cyc) begin
          in_cyc = 1; pre = 0; slen = 0; hlen = 0;
          bad_cs = 0; bad_a = 0; bad_d = 0; bad_k = 0;
        end
        if (bus_cs_n != ~(8'h01 << q[0].dev)) bad_cs = 1;
        if (bus_addr_lo != q[0].addr[7:0]) bad_a = 1;
        if (q[0].wr ? !(bus_data_oe && bus_data_out == q[0].wdata) : bus_data_oe) bad_d = 1;
        if (stb) begin
          if (slen == 0) begin  // R4 and R8: earliest legal strobe start
            ok_s  = pre >= q[0].setup + 1;
            ok_r  = !have_prev || gap >= prev_recov + 1;
            tight = (pre == q[0].setup + 1) || (have_prev && gap == prev_recov + 1);
            check(ok_s && ok_r && tight, "R4 R8 strobe start", pre, q[0].setup + 1);
          end
          if (q[0].wr ? (bus_wr_n || !bus_rd_n) : (bus_rd_n || !bus_wr_n)) bad_k = 1;
          slen++;
        end else if (slen == 0) pre++;
        else hlen++;
      end else if (in_cyc) begin
        it = q.pop_front();
        in_cyc = 0;
        exp_s = ((it.pulse > it.wt) ? it.pulse : it.wt) + 1;
        check(slen == exp_s, "R5 R6 strobe width", slen, exp_s);
        check(hlen == it.hold + 1, "R7 hold", hlen, it.hold + 1);
        check(!bad_cs, "R3 select", bus_cs_n, it.dev);
        check(!bad_a, "R2 low address", bus_addr_lo, it.addr[7:0]);
        check(!bad_d, "R9 data drive", bus_data_out, it.wdata);
        check(!bad_k, "R5 strobe kind", it.wr, it.wr);
        check(rsp_done, "R10 done timing", rsp_done, 1);
        if (!it.wr)
          check(rsp_rdata == it.rbase + 8'(exp_s - 1), "R10 read data", rsp_rdata,
                it.rbase + 8'(exp_s - 1));
        prev_recov = it.recov;
        have_prev = 1;
      end
      if (stb) gap = 0; else gap++;
    end
  end

  task automatic set_cfg(input int s, input int p, input int h, input int r);
    @(negedge clk);
    cfg_setup = 4'(s); cfg_pulse = 4'(p); cfg_hold = 4'(h); cfg_recov = 4'(r);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_setup = s; m_pulse = p; m_hold = h; m_recov = r;
  endtask

  task automatic issue(input logic [2:0] dev, input logic [15:0] addr, input logic wr,
                       input logic [7:0] wdata, input logic [7:0] rbase, input int wt);
    item_t it;
    it.dev = dev; it.addr = addr; it.wr = wr; it.wdata = wdata; it.rbase = rbase;
    it.wt = wt; it.setup = m_setup; it.pulse = m_pulse; it.hold = m_hold; it.recov = m_recov;
    q.push_back(it);
    req_dev = dev; req_addr = addr; req_write = wr; req_wdata = wdata;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(req_ready && q.size() == 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check(&bus_cs_n && bus_rd_n && bus_wr_n && !bus_latch_en && !bus_data_oe && !rsp_done,
          "R1 in reset", bus_cs_n, 8'hFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(&bus_cs_n && bus_rd_n && bus_wr_n && !bus_data_oe && req_ready && !rsp_done,
          "R1 after reset", req_ready, 1);

    // R1 reset timing of 15 in every field, write cycle
    issue(3'd2, 16'hA55A, 1'b1, 8'h3C, 8'h00, 0);
    @(negedge clk);
    check(!req_ready, "R11 busy", req_ready, 0);
    wait_idle();

    set_cfg(1, 2, 0, 0);
    issue(3'd5, 16'h1234, 1'b1, 8'hC3, 8'h00, 0);
    wait_idle();
    issue(3'd0, 16'hBEEF, 1'b0, 8'h00, 8'h40, 0);
    wait_idle();
    // R6 ready held low for six strobe cycles
    issue(3'd7, 16'h0F0F, 1'b0, 8'h00, 8'h90, 6);
    wait_idle();
    issue(3'd6, 16'h7001, 1'b1, 8'h5A, 8'h00, 5);
    wait_idle();

    // R8 recovery longer than the natural gap, back to back
    set_cfg(0, 0, 0, 15);
    issue(3'd1, 16'h2001, 1'b1, 8'h11, 8'h00, 0);
    issue(3'd1, 16'h2002, 1'b1, 8'h22, 8'h00, 0);
    issue(3'd4, 16'h2003, 1'b0, 8'h00, 8'h70, 0);
    wait_idle();

    // R12 timing write during a cycle is ignored
    set_cfg(3, 1, 2, 0);
    issue(3'd3, 16'h4400, 1'b0, 8'h00, 8'h20, 0);
    cfg_setup = 4'd9; cfg_pulse = 4'd9; cfg_hold = 4'd9; cfg_recov = 4'd9;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_idle();
    issue(3'd3, 16'h4401, 1'b1, 8'h99, 8'h00, 0);  // checked against the earlier fields
    wait_idle();

    // R3 every select line
    set_cfg(0, 0, 1, 2);
    for (int d = 0; d < 8; d++) begin
      issue(3'(d), {8'(d), 8'(8'hF0 | d)}, d[0], 8'(d * 17), 8'(d * 8), 0);
    end
    wait_idle();

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R11 one cycle per request", q.size(), 0);
    finish_run();
  end
endmodule